// File: doc/BRIEF.md
# Miss Ack-Count Completion Tracker

This block follows one outstanding read miss from the moment it is issued until every expected reply has come back. When a shared or exclusive read goes out, the block loads a counter with the number of first-level caches in the system. That figure stands for one reply from each peer cache plus one from memory. Each incoming reply carries its own ack amount, and the block subtracts that amount. The block also notes whether any replier kept a shared copy. It records who replied last and when the first reply arrived.

When a reply brings the counter to zero, the block fires a single completion pulse. The pulse is typed by whether sharers were seen. An upgrade from a line the requester already owns starts one lower, because the requester already has the data. Single-step increment and decrement strobes let the surrounding controller adjust the count, for example when ownership is lost to a foreign exclusive read. The request itself is announced on an output a configurable number of cycles after the issue decision.

Top module: `miss_ack_tracker`

## Requirements
- R1: After reset the tracker is idle: busy, pendingCnt, sharersSeen, lastResponder, firstRspTime, trigValid, trigNoSharers, underflowErr and reqIssue are all 0.
- R2: An issueValid pulse with issueUpgrade=0 sets busy and loads pendingCnt with NUM_CACHES (default 4). In the same step it clears sharersSeen, lastResponder, firstRspTime and underflowErr, and re-arms the completion trigger.
- R3: An issueValid pulse with issueUpgrade=1 loads pendingCnt with NUM_CACHES-1 (default 3).
- R4: While busy, a rspValid cycle subtracts rspAcks from pendingCnt and stores rspSender in lastResponder, both visible after the next clock edge. An rspAcks value of zero is illegal.
- R5: A response with rspShared=1 sets sharersSeen. The flag stays set until the next issue or release.
- R6: If pendingCnt becomes zero through a response, trigValid is 1 for exactly one cycle after that edge. In that cycle trigNoSharers=1 only if no response since issue, including this one, had rspShared=1.
- R7: At most one completion pulse is emitted per issue. A later return to zero does not raise trigValid again.
- R8: incOne adds one and decOne subtracts one from pendingCnt while busy. A count reaching zero through these strobes alone raises no trigger.
- R9: On a response, firstRspTime captures nowTime only while its stored value is zero.
- R10: If pendingCnt goes below zero, underflowErr rises and stays at 1 until the next issue or release.
- R11: While idle, rspValid, incOne and decOne have no effect on any output.
- R12: A dealloc pulse without issueValid returns the tracker to idle and clears every field to 0.
- R13: reqIssue pulses for one cycle, ISSUE_LAT clock edges (default 2) after the edge that samples issueValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Allocate tracker and issue a read |
| issueUpgrade | input | 1 | The issue is an upgrade from an owned line |
| rspValid | input | 1 | A response arrives this cycle |
| rspAcks | input | ACK_W | Ack amount carried by the response |
| rspShared | input | 1 | Responder kept a shared copy |
| rspSender | input | ID_W | Responder identifier |
| nowTime | input | TIME_W | Current timestamp |
| incOne | input | 1 | Add one to the pending count |
| decOne | input | 1 | Subtract one from the pending count |
| dealloc | input | 1 | Release the tracker |
| reqIssue | output | 1 | Delayed request launch pulse |
| busy | output | 1 | Tracker allocated |
| pendingCnt | output | CNT_W | Signed count of outstanding replies |
| sharersSeen | output | 1 | A shared responder was observed |
| lastResponder | output | ID_W | Sender of the latest response |
| firstRspTime | output | TIME_W | Timestamp of the first response |
| trigValid | output | 1 | One-shot completion trigger |
| trigNoSharers | output | 1 | Completion type: 1 = no sharers, 0 = sharers seen |
| underflowErr | output | 1 | Count went negative |

## Verification
A wrong seed or a wrong subtraction appears on pendingCnt one edge after the faulty cycle. It then moves the completion pulse earlier, later, or removes it, so the error is visible a few cycles later on trigValid. A sharers flag that leaks from one allocation to the next shows up only on the trigger type at the following completion. The test therefore chains two allocations, the first with sharers and the second without. A missed re-arm or a missed one-shot guard shows as an absent or a repeated pulse on the cycle after a response drives the count to zero.

// File: rtl/mat_pkg.sv
package mat_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_WAIT = 2'd1,
    TRK_DONE = 2'd2
  } trkState_t;

  typedef struct packed {
    logic seedLd;
    logic seedUpg;
    logic clrAll;
    logic takeRsp;
    logic takeInc;
    logic takeDec;
  } trkStrobes_t;

endpackage

// File: rtl/mat_ctrl.sv
module mat_ctrl
  import mat_pkg::*;
#(
  parameter int ISSUE_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic        issueUpgrade,
  input  logic        rspValid,
  input  logic        incOne,
  input  logic        decOne,
  input  logic        dealloc,
  input  logic        nextZero,
  input  logic        sharersNext,
  output trkStrobes_t strb,
  output logic        busy,
  output logic        trigValid,
  output logic        trigNoSharers,
  output logic        reqIssue
);

  trkState_t state, stateNext;
  logic live;
  logic fire;

  assign live = (state != TRK_IDLE);
  assign busy = live;

  always_comb begin
    strb.seedLd  = issueValid;
    strb.seedUpg = issueValid & issueUpgrade;
    strb.clrAll  = dealloc & ~issueValid;
    strb.takeRsp = live & rspValid & ~issueValid & ~dealloc;
    strb.takeInc = live & incOne & ~issueValid & ~dealloc;
    strb.takeDec = live & decOne & ~issueValid & ~dealloc;
  end

  // completion fires only from the armed state
  assign fire = strb.takeRsp & nextZero & (state == TRK_WAIT);

  always_comb begin
    stateNext = state;
    if (issueValid)        stateNext = TRK_WAIT;
    else if (strb.clrAll)  stateNext = TRK_IDLE;
    else if (fire)         stateNext = TRK_DONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= TRK_IDLE;
      trigValid     <= 1'b0;
      trigNoSharers <= 1'b0;
    end else begin
      state         <= stateNext;
      trigValid     <= fire;
      trigNoSharers <= fire & ~sharersNext;
    end
  end

  generate
    if (ISSUE_LAT == 0) begin : gLat0
      assign reqIssue = issueValid;
    end else if (ISSUE_LAT == 1) begin : gLat1
      logic issD;
      always_ff @(posedge clk) begin
        if (!rstN) issD <= 1'b0;
        else       issD <= issueValid;
      end
      assign reqIssue = issD;
    end else begin : gLatN
      logic [ISSUE_LAT-1:0] issPipe;
      always_ff @(posedge clk) begin
        if (!rstN) issPipe <= '0;
        else       issPipe <= {issPipe[ISSUE_LAT-2:0], issueValid};
      end
      assign reqIssue = issPipe[ISSUE_LAT-1];
    end
  endgenerate

  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigValid |=> !trigValid);

  assert_single_fire_R7: assert property (@(posedge clk) disable iff (!rstN)
    trigValid |-> (state == TRK_DONE));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == TRK_IDLE) && !issueValid |=> (state == TRK_IDLE) && !trigValid);

endmodule

// File: rtl/mat_dp.sv
module mat_dp
  import mat_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ACK_W      = 3,
  parameter int ID_W       = 3,
  parameter int TIME_W     = 16,
  parameter int CNT_W      = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  trkStrobes_t              strb,
  input  logic [ACK_W-1:0]         rspAcks,
  input  logic                     rspShared,
  input  logic [ID_W-1:0]          rspSender,
  input  logic [TIME_W-1:0]        nowTime,
  output logic signed [CNT_W-1:0]  pendingCnt,
  output logic                     sharersSeen,
  output logic [ID_W-1:0]          lastResponder,
  output logic [TIME_W-1:0]        firstRspTime,
  output logic                     underflowErr,
  output logic                     nextZero,
  output logic                     sharersNext
);

  localparam logic signed [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic signed [CNT_W-1:0] SEED_FULL = CNT_W'(NUM_CACHES);

  logic signed [CNT_W-1:0] ackTerm;
  logic signed [CNT_W-1:0] incTerm;
  logic signed [CNT_W-1:0] decTerm;
  logic signed [CNT_W-1:0] nextCnt;
  logic signed [CNT_W-1:0] seedVal;
  logic                    adjusting;

  always_comb begin
    ackTerm   = strb.takeRsp ? $signed({{(CNT_W-ACK_W){1'b0}}, rspAcks}) : '0;
    incTerm   = strb.takeInc ? ONE : '0;
    decTerm   = strb.takeDec ? ONE : '0;
    nextCnt   = pendingCnt - ackTerm + incTerm - decTerm;
    seedVal   = strb.seedUpg ? (SEED_FULL - ONE) : SEED_FULL;
    adjusting = strb.takeRsp | strb.takeInc | strb.takeDec;
  end

  assign nextZero    = (nextCnt == '0);
  assign sharersNext = sharersSeen | (strb.takeRsp & rspShared);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingCnt    <= '0;
      sharersSeen   <= 1'b0;
      lastResponder <= '0;
      firstRspTime  <= '0;
      underflowErr  <= 1'b0;
    end else if (strb.seedLd) begin
      pendingCnt    <= seedVal;
      sharersSeen   <= 1'b0;
      lastResponder <= '0;
      firstRspTime  <= '0;
      underflowErr  <= 1'b0;
    end else if (strb.clrAll) begin
      pendingCnt    <= '0;
      sharersSeen   <= 1'b0;
      lastResponder <= '0;
      firstRspTime  <= '0;
      underflowErr  <= 1'b0;
    end else begin
      pendingCnt <= nextCnt;
      if (strb.takeRsp) begin
        sharersSeen   <= sharersNext;
        lastResponder <= rspSender;
        if (firstRspTime == '0) firstRspTime <= nowTime;
      end
      if (adjusting && (nextCnt < 0)) underflowErr <= 1'b1;
    end
  end

  assert_ack_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeRsp |-> (rspAcks != '0));

  assert_seed_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.seedLd |=> (pendingCnt > 0) && (pendingCnt <= SEED_FULL) && !sharersSeen);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr && !strb.seedLd && !strb.clrAll |=> underflowErr);

  assert_release_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (pendingCnt == '0) && (lastResponder == '0) && !underflowErr);

endmodule

// File: rtl/miss_ack_tracker.sv
module miss_ack_tracker
  import mat_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int ID_W       = 3,
  parameter int TIME_W     = 16,
  parameter int ISSUE_LAT  = 2,
  localparam int ACK_W     = $clog2(NUM_CACHES + 1),
  localparam int CNT_W     = ACK_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    issueValid,
  input  logic                    issueUpgrade,
  input  logic                    rspValid,
  input  logic [ACK_W-1:0]        rspAcks,
  input  logic                    rspShared,
  input  logic [ID_W-1:0]         rspSender,
  input  logic [TIME_W-1:0]       nowTime,
  input  logic                    incOne,
  input  logic                    decOne,
  input  logic                    dealloc,
  output logic                    reqIssue,
  output logic                    busy,
  output logic signed [CNT_W-1:0] pendingCnt,
  output logic                    sharersSeen,
  output logic [ID_W-1:0]         lastResponder,
  output logic [TIME_W-1:0]       firstRspTime,
  output logic                    trigValid,
  output logic                    trigNoSharers,
  output logic                    underflowErr
);

  trkStrobes_t strb;
  logic        nextZero;
  logic        sharersNext;

  mat_ctrl #(.ISSUE_LAT(ISSUE_LAT)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .issueValid   (issueValid),
    .issueUpgrade (issueUpgrade),
    .rspValid     (rspValid),
    .incOne       (incOne),
    .decOne       (decOne),
    .dealloc      (dealloc),
    .nextZero     (nextZero),
    .sharersNext  (sharersNext),
    .strb         (strb),
    .busy         (busy),
    .trigValid    (trigValid),
    .trigNoSharers(trigNoSharers),
    .reqIssue     (reqIssue)
  );

  mat_dp #(
    .NUM_CACHES(NUM_CACHES),
    .ACK_W     (ACK_W),
    .ID_W      (ID_W),
    .TIME_W    (TIME_W),
    .CNT_W     (CNT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .rspAcks      (rspAcks),
    .rspShared    (rspShared),
    .rspSender    (rspSender),
    .nowTime      (nowTime),
    .pendingCnt   (pendingCnt),
    .sharersSeen  (sharersSeen),
    .lastResponder(lastResponder),
    .firstRspTime (firstRspTime),
    .underflowErr (underflowErr),
    .nextZero     (nextZero),
    .sharersNext  (sharersNext)
  );

endmodule

// File: tb/tb_miss_ack_tracker.sv
module tb_miss_ack_tracker;

  localparam int PERIOD = 10;
  localparam int NV     = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 0, issueUpgrade = 0, rspValid = 0, rspShared = 0;
  logic incOne = 0, decOne = 0, dealloc = 0;
  logic [2:0] rspAcks = '0;
  logic [2:0] rspSender = '0;
  logic [15:0] nowTime = '0;
  logic reqIssue, busy, sharersSeen, trigValid, trigNoSharers, underflowErr;
  logic signed [4:0] pendingCnt;
  logic [2:0] lastResponder;
  logic [15:0] firstRspTime;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD/2) clk = ~clk;

  miss_ack_tracker dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUpgrade(issueUpgrade),
    .rspValid(rspValid), .rspAcks(rspAcks), .rspShared(rspShared), .rspSender(rspSender),
    .nowTime(nowTime), .incOne(incOne), .decOne(decOne), .dealloc(dealloc),
    .reqIssue(reqIssue), .busy(busy), .pendingCnt(pendingCnt), .sharersSeen(sharersSeen),
    .lastResponder(lastResponder), .firstRspTime(firstRspTime), .trigValid(trigValid),
    .trigNoSharers(trigNoSharers), .underflowErr(underflowErr)
  );

  typedef struct packed {
    int iss; int upg; int rv; int acks; int sh; int snd; int inc; int dec; int dal; int now;
    int tag;
    int eBusy; int eCnt; int eSh; int eTrig; int eNoSh; int eLast; int eFirst; int eErr;
  } vec_t;

  // iss upg rv acks sh snd inc dec dal now | tag | busy cnt sh trig nosh last first err
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,0,0,0,0, 0,  2, 1, 4,0,0,0,0, 0,0},  // R2 seed
    '{0,0,1,1,0,2,0,0,0,10,  4, 1, 3,0,0,0,2,10,0},  // R4 subtract, R9 first time
    '{0,0,1,1,1,3,0,0,0,20,  5, 1, 2,1,0,0,3,10,0},  // R5 shared seen
    '{0,0,1,2,0,1,0,0,0,30,  6, 1, 0,1,1,0,1,10,0},  // R6 complete with sharers
    '{0,0,0,0,0,0,0,0,0,35,  6, 1, 0,1,0,0,1,10,0},  // R6 pulse drops
    '{0,0,0,0,0,0,1,0,0,36,  8, 1, 1,1,0,0,1,10,0},  // R8 increment
    '{0,0,1,1,0,4,0,0,0,40,  7, 1, 0,1,0,0,4,10,0},  // R7 no second trigger
    '{0,0,0,0,0,0,0,0,1,41, 12, 0, 0,0,0,0,0, 0,0},  // R12 release
    '{0,0,1,1,1,5,0,0,0,45, 11, 0, 0,0,0,0,0, 0,0},  // R11 idle response ignored
    '{0,0,0,0,0,0,1,0,0,46, 11, 0, 0,0,0,0,0, 0,0},  // R11 idle increment ignored
    '{1,1,0,0,0,0,0,0,0,47,  3, 1, 3,0,0,0,0, 0,0},  // R3 upgrade seed
    '{0,0,1,1,0,5,0,0,0, 0,  9, 1, 2,0,0,0,5, 0,0},  // R9 zero time kept
    '{0,0,1,1,1,6,0,0,0,50,  9, 1, 1,1,0,0,6,50,0},  // R9 latched now
    '{0,0,0,0,0,0,0,1,0,51,  8, 1, 0,1,0,0,6,50,0},  // R8 decrement to zero, no trigger
    '{0,0,1,1,0,7,0,0,0,60, 10, 1,-1,1,0,0,7,50,1},  // R10 underflow
    '{1,0,0,0,0,0,0,0,0,65,  2, 1, 4,0,0,0,0, 0,0},  // R2 reseed clears flags
    '{0,0,1,4,0,1,0,0,0,70,  6, 1, 0,0,1,1,1,70,0},  // R6 complete, no sharers
    '{0,0,0,0,0,0,0,0,0,71,  6, 1, 0,0,0,0,1,70,0}   // R6 pulse drops
  };

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    issueValid = 0; issueUpgrade = 0; rspValid = 0; rspAcks = '0; rspShared = 0;
    rspSender = '0; incOne = 0; decOne = 0; dealloc = 0;
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 50000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "pendingCnt", int'(pendingCnt), 0);
    chk("R1", "sharersSeen", sharersSeen, 0);
    chk("R1", "lastResponder", lastResponder, 0);
    chk("R1", "firstRspTime", firstRspTime, 0);
    chk("R1", "trigValid", trigValid, 0);
    chk("R1", "trigNoSharers", trigNoSharers, 0);
    chk("R1", "underflowErr", underflowErr, 0);
    chk("R1", "reqIssue", reqIssue, 0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      @(negedge clk);
      issueValid   = VEC[i].iss[0];
      issueUpgrade = VEC[i].upg[0];
      rspValid     = VEC[i].rv[0];
      rspAcks      = VEC[i].acks[2:0];
      rspShared    = VEC[i].sh[0];
      rspSender    = VEC[i].snd[2:0];
      incOne       = VEC[i].inc[0];
      decOne       = VEC[i].dec[0];
      dealloc      = VEC[i].dal[0];
      nowTime      = VEC[i].now[15:0];
      stepEdge();
      tg = $sformatf("R%0d v%0d", VEC[i].tag, i);
      chk(tg, "busy", busy, VEC[i].eBusy);
      chk(tg, "pendingCnt", int'(pendingCnt), VEC[i].eCnt);
      chk(tg, "sharersSeen", sharersSeen, VEC[i].eSh);
      chk(tg, "trigValid", trigValid, VEC[i].eTrig);
      chk(tg, "trigNoSharers", trigNoSharers, VEC[i].eNoSh);
      chk(tg, "lastResponder", lastResponder, VEC[i].eLast);
      chk(tg, "firstRspTime", firstRspTime, VEC[i].eFirst);
      chk(tg, "underflowErr", underflowErr, VEC[i].eErr);
    end

    // R13 issue-to-request latency of 2 edges
    @(negedge clk);
    idleInputs();
    issueValid = 1;
    stepEdge();
    chk("R13", "reqIssue edge1", reqIssue, 0);
    @(negedge clk);
    idleInputs();
    stepEdge();
    chk("R13", "reqIssue edge2", reqIssue, 1);
    @(negedge clk);
    stepEdge();
    chk("R13", "reqIssue edge3", reqIssue, 0);

    // R6 the completing response itself is shared: type is all-acks with sharers
    @(negedge clk);
    rspValid = 1; rspAcks = 3'd4; rspShared = 1; rspSender = 3'd2;
    stepEdge();
    chk("R6", "trigValid shared final", trigValid, 1);
    chk("R6", "trigNoSharers shared final", trigNoSharers, 0);
    chk("R5", "sharersSeen shared final", sharersSeen, 1);

    @(negedge clk);
    idleInputs();
    stepEdge();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule